// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an unpacked floating-point operand into a 32-bit two's-complement integer. The operand arrives as a class code, a sign, a signed unbiased exponent and a 64-bit normalised mantissa whose leading one sits at bit 63. The number it represents is `mantissa * 2^(exponent - 63)`. The conversion always discards the fraction, so it truncates toward zero whatever rounding mode the rest of the datapath uses.

The result saturates to a bound that depends on the sign. The converter reports two exception flags: one for a lost fraction (inexact) and one for a value that cannot be represented (invalid). When a conversion overflows, the invalid flag is raised and the inexact flag is suppressed. Each operand is presented for one cycle with `in_valid`, and the integer and flags appear registered one cycle later with `out_valid`.

Top module: `fp2int_conv`

## Requirements
- R1: While `rst_n` is low and until the first accepted operand, `out_valid` is 0, `out_int` is 0 and both flags are 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_int`, `out_inexact` and `out_invalid` keep their previous values.
- R3: Class code 0 (zero) gives `out_int` = 0 with both flags clear, whatever the sign.
- R4: A normal operand (class code 1) whose value is a whole number inside the range gives that integer in two's complement, with both flags clear.
- R5: A normal operand with fraction bits below the binary point gives the integer part truncated toward zero and sets `out_inexact`. This includes negative exponents, which give 0 with `out_inexact` set.
- R6: A normal operand whose exponent, read as a signed 16-bit value, is 32 or more overflows.
- R7: A normal operand whose truncated magnitude is at least 0x80000000 plus the sign bit overflows. A negative operand of magnitude exactly 0x80000000 therefore converts to 0x80000000 without overflow, while the positive one overflows.
- R8: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 are treated as an overflow.
- R9: On overflow, `out_int` is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1. `out_invalid` is 1 and `out_inexact` is 0.
- R10: `out_inexact` and `out_invalid` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign, 1 for negative |
| in_exp | input | 16 | Signed unbiased exponent |
| in_mant | input | 64 | Mantissa with leading one at bit 63 |
| out_valid | output | 1 | Result present this cycle |
| out_int | output | 32 | Two's-complement integer result |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Operand not representable; result saturated |

## Verification
The assertions expect every class-1 operand to carry a normalised mantissa with bit 63 set. Both the overflow and the inexact properties depend on that form. Every normal vector in the stimulus is built with its leading one at bit 63, including the boundary cases at ±2^31, ±(2^31−1) and ±0.5. The class field is not restricted: the stimulus also drives an unused code, since the block must treat it as invalid.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  parameter int MANT_W = 64;
  parameter int EXP_W  = 16;
  parameter int INT_W  = 32;
  parameter int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ZERO = 3'd0,
    CLS_NORM = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fp_class_e;
endpackage

// File: rtl/fp2int_align.sv
// Moves the integer part of the mantissa into an INT_W-bit word and
// reports whether any bit fell below the binary point.
module fp2int_align #(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 16,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  output logic [INT_W-1:0]  mag_o,
  output logic              lost_o,
  output logic              big_o
);
  localparam int SH_W = $clog2(MANT_W);

  logic              exp_neg;
  logic [SH_W-1:0]   sh_amt;
  logic [MANT_W-1:0] shifted;
  logic [MANT_W-1:0] below;

  always_comb begin
    exp_neg = exp_i[EXP_W-1];
    big_o   = !exp_neg && ($signed(exp_i) > $signed(EXP_W'(INT_W - 1)));
    sh_amt  = SH_W'(MANT_W - 1) - exp_i[SH_W-1:0];
    shifted = mant_i >> sh_amt;
    below   = mant_i << (SH_W'(MANT_W) - sh_amt);
    if (exp_neg) begin
      mag_o  = '0;
      lost_o = |mant_i;
    end else if (big_o) begin
      mag_o  = '0;
      lost_o = 1'b0;
    end else begin
      mag_o  = shifted[INT_W-1:0];
      lost_o = (sh_amt == '0) ? 1'b0 : |below;
    end
  end
endmodule

// File: rtl/fp2int_sat.sv
// Picks the final integer and flags from the class, sign and aligned magnitude.
module fp2int_sat
  import fp2int_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [CLS_W-1:0] cls_i,
  input  logic             sign_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             lost_i,
  input  logic             big_i,
  output logic [INT_W-1:0] res_o,
  output logic             nx_o,
  output logic             nv_o
);
  localparam logic [INT_W:0] LIMIT = (INT_W+1)'(1) << (INT_W - 1);

  logic           ovf_num;
  logic [INT_W:0] limit_s;
  logic [INT_W-1:0] sat_val;

  always_comb begin
    limit_s = LIMIT + (INT_W+1)'(sign_i);
    ovf_num = big_i || ({1'b0, mag_i} >= limit_s);
    sat_val = sign_i ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    res_o   = '0;
    nx_o    = 1'b0;
    nv_o    = 1'b0;
    case (cls_i)
      CLS_ZERO: begin
        res_o = '0;
      end
      CLS_NORM: begin
        if (ovf_num) begin
          res_o = sat_val;
          nv_o  = 1'b1;
        end else begin
          res_o = sign_i ? (~mag_i + INT_W'(1)) : mag_i;
          nx_o  = lost_i;
        end
      end
      default: begin
        res_o = sat_val;
        nv_o  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fp2int_outreg.sv
// Output stage: result and flags load on the accept strobe, valid follows it.
module fp2int_outreg #(
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [INT_W-1:0] res_i,
  input  logic             nx_i,
  input  logic             nv_i,
  output logic             vld_o,
  output logic [INT_W-1:0] res_o,
  output logic             nx_o,
  output logic             nv_o
);
  logic [INT_W-1:0] res_d;
  logic             nx_d;
  logic             nv_d;

  always_comb begin
    res_d = res_o;
    nx_d  = nx_o;
    nv_d  = nv_o;
    if (load_i) begin
      res_d = res_i;
      nx_d  = nx_i;
      nv_d  = nv_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      res_o <= '0;
      nx_o  <= 1'b0;
      nv_o  <= 1'b0;
    end else begin
      vld_o <= load_i;
      res_o <= res_d;
      nx_o  <= nx_d;
      nv_o  <= nv_d;
    end
  end
endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
  import fp2int_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CLS_W-1:0]  in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  output logic              out_valid,
  output logic [INT_W-1:0]  out_int,
  output logic              out_inexact,
  output logic              out_invalid
);
  logic [INT_W-1:0] mag;
  logic             lost;
  logic             big;
  logic [INT_W-1:0] res;
  logic             nx;
  logic             nv;

  fp2int_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) u_align (
    .exp_i  (in_exp),
    .mant_i (in_mant),
    .mag_o  (mag),
    .lost_o (lost),
    .big_o  (big)
  );

  fp2int_sat #(.INT_W(INT_W)) u_sat (
    .cls_i  (in_class),
    .sign_i (in_sign),
    .mag_i  (mag),
    .lost_i (lost),
    .big_i  (big),
    .res_o  (res),
    .nx_o   (nx),
    .nv_o   (nv)
  );

  fp2int_outreg #(.INT_W(INT_W)) u_outreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (in_valid),
    .res_i  (res),
    .nx_i   (nx),
    .nv_i   (nv),
    .vld_o  (out_valid),
    .res_o  (out_int),
    .nx_o   (out_inexact),
    .nv_o   (out_invalid)
  );
endmodule

// File: rtl/fp2int_conv_chk.sv
module fp2int_conv_chk
  import fp2int_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CLS_W-1:0]  in_class,
  input logic              in_sign,
  input logic [EXP_W-1:0]  in_exp,
  input logic [MANT_W-1:0] in_mant,
  input logic              out_valid,
  input logic [INT_W-1:0]  out_int,
  input logic              out_inexact,
  input logic              out_invalid
);
  localparam logic [INT_W-1:0] POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_int) && $stable(out_inexact) && $stable(out_invalid)));

  assert_zero_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == CLS_ZERO) |=> (out_int == '0 && !out_inexact && !out_invalid));

  assert_big_exp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == CLS_NORM && !in_exp[EXP_W-1] &&
     $signed(in_exp) >= $signed(EXP_W'(INT_W))) |=> out_invalid);

  assert_special_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class != CLS_ZERO && in_class != CLS_NORM) |=> out_invalid);

  assert_sat_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (out_int == POS_SAT || out_int == NEG_SAT));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_inexact && out_invalid));
endmodule

bind fp2int_conv fp2int_conv_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_class    (in_class),
  .in_sign     (in_sign),
  .in_exp      (in_exp),
  .in_mant     (in_mant),
  .out_valid   (out_valid),
  .out_int     (out_int),
  .out_inexact (out_inexact),
  .out_invalid (out_invalid)
);

// File: tb/test_fp2int_conv.sv
`timescale 1ns/1ps
module test_fp2int_conv;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_class;
  logic        in_sign;
  logic [15:0] in_exp;
  logic [63:0] in_mant;
  logic        out_valid;
  logic [31:0] out_int;
  logic        out_inexact;
  logic        out_invalid;

  int n_run;
  int n_fail;

  fp2int_conv i_fp2int_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .out_valid(out_valid), .out_int(out_int),
    .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [63:0] ONE  = 64'h8000_0000_0000_0000;
  localparam int NV = 24;
  // {class, sign, exp, mant, expected int, inexact, invalid}
  localparam logic [117:0] VEC [NV] = '{
    {3'd1, 1'b0, 16'd0,     ONE,                   32'h0000_0001, 1'b0, 1'b0}, // R4 +1
    {3'd1, 1'b1, 16'd0,     ONE,                   32'hFFFF_FFFF, 1'b0, 1'b0}, // R4 -1
    {3'd1, 1'b0, 16'd1,     64'hC000_0000_0000_0000, 32'h0000_0003, 1'b0, 1'b0}, // R4 3
    {3'd1, 1'b0, 16'd30,    64'hFFFF_FFFE_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b0}, // R4 2^31-1
    {3'd1, 1'b1, 16'd30,    64'hFFFF_FFFE_0000_0000, 32'h8000_0001, 1'b0, 1'b0}, // R4 -(2^31-1)
    {3'd1, 1'b0, 16'd1,     64'hE000_0000_0000_0000, 32'h0000_0003, 1'b1, 1'b0}, // R5 3.5
    {3'd1, 1'b1, 16'd1,     64'hE000_0000_0000_0000, 32'hFFFF_FFFD, 1'b1, 1'b0}, // R5 -3.5
    {3'd1, 1'b0, 16'hFFFF,  ONE,                   32'h0000_0000, 1'b1, 1'b0}, // R5 +0.5
    {3'd1, 1'b1, 16'hFFFF,  ONE,                   32'h0000_0000, 1'b1, 1'b0}, // R5 -0.5
    {3'd1, 1'b1, 16'hFF9C,  ONE,                   32'h0000_0000, 1'b1, 1'b0}, // R5 tiny
    {3'd1, 1'b0, 16'd30,    64'hFFFF_FFFF_FFFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0}, // R5
    {3'd1, 1'b1, 16'd30,    64'hFFFF_FFFF_0000_0000, 32'h8000_0001, 1'b1, 1'b0}, // R5
    {3'd1, 1'b0, 16'd32,    ONE,                   32'h7FFF_FFFF, 1'b0, 1'b1}, // R6 +2^32
    {3'd1, 1'b1, 16'h7FFF,  ONE,                   32'h8000_0000, 1'b0, 1'b1}, // R6 huge
    {3'd1, 1'b0, 16'd62,    64'hFFFF_FFFF_FFFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R6
    {3'd1, 1'b0, 16'd31,    ONE,                   32'h7FFF_FFFF, 1'b0, 1'b1}, // R7 +2^31
    {3'd1, 1'b1, 16'd31,    ONE,                   32'h8000_0000, 1'b0, 1'b0}, // R7 -2^31
    {3'd1, 1'b1, 16'd31,    64'h8000_0000_0000_0001, 32'h8000_0000, 1'b1, 1'b0}, // R7 -2^31-frac
    {3'd1, 1'b1, 16'd31,    64'hC000_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R7 -3*2^30
    {3'd2, 1'b0, 16'd0,     ONE,                   32'h7FFF_FFFF, 1'b0, 1'b1}, // R8 +inf
    {3'd2, 1'b1, 16'd0,     ONE,                   32'h8000_0000, 1'b0, 1'b1}, // R8 -inf
    {3'd3, 1'b0, 16'd5,     64'hC000_0000_0000_0000, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R8 qnan
    {3'd4, 1'b1, 16'd5,     64'hA000_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R8 snan
    {3'd6, 1'b0, 16'd0,     ONE,                   32'h7FFF_FFFF, 1'b0, 1'b1}  // R8 unused
  };

  task automatic check(input string req, input logic [31:0] got_i, input logic got_nx,
                       input logic got_nv, input logic [31:0] exp_i, input logic exp_nx,
                       input logic exp_nv);
    n_run++;
    if (got_i !== exp_i || got_nx !== exp_nx || got_nv !== exp_nv) begin
      n_fail++;
      $display("FAIL %s: int=%h nx=%b nv=%b expected int=%h nx=%b nv=%b",
               req, got_i, got_nx, got_nv, exp_i, exp_nx, exp_nv);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic expv);
    n_run++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, expv);
    end
  endtask

  task automatic drive(input logic [117:0] v);
    in_class = v[117:115];
    in_sign  = v[114];
    in_exp   = v[113:98];
    in_mant  = v[97:34];
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", out_int, out_inexact, out_invalid, 32'h0, 1'b0, 1'b0);
    check_bit("R1 reset valid", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 idle after reset", out_valid, 1'b0);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k]);
      in_valid = 1'b1;
      @(negedge clk);
      check_bit("R2 valid one cycle later", out_valid, 1'b1);
      check($sformatf("vector %0d (R3-R9)", k), out_int, out_inexact, out_invalid,
            VEC[k][33:2], VEC[k][1], VEC[k][0]);
      check_bit("R10 flags exclusive", out_inexact && out_invalid, 1'b0);
      in_valid = 1'b0;
    end

    // R2: idle input changes do not reach the outputs
    drive({3'd1, 1'b0, 16'd1, 64'hE000_0000_0000_0000, 32'h0, 1'b0, 1'b0});
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    drive({3'd2, 1'b1, 16'd0, ONE, 32'h0, 1'b0, 1'b0});
    @(negedge clk);
    check_bit("R2 valid drops", out_valid, 1'b0);
    check("R2 hold while idle", out_int, out_inexact, out_invalid, 32'h3, 1'b1, 1'b0);

    // R3: signed zeros, back to back
    drive({3'd0, 1'b1, 16'd40, ONE, 32'h0, 1'b0, 1'b0});
    in_valid = 1'b1;
    @(negedge clk);
    check("R3 negative zero", out_int, out_inexact, out_invalid, 32'h0, 1'b0, 1'b0);
    drive({3'd0, 1'b0, 16'd0, 64'h0, 32'h0, 1'b0, 1'b0});
    @(negedge clk);
    check("R3 positive zero", out_int, out_inexact, out_invalid, 32'h0, 1'b0, 1'b0);
    check_bit("R2 valid back to back", out_valid, 1'b1);
    in_valid = 1'b0;

    // R1: reset in mid-run clears the outputs
    drive({3'd2, 1'b0, 16'd0, ONE, 32'h0, 1'b0, 1'b0});
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 async reset", out_int, out_inexact, out_invalid, 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule